// File: doc/BRIEF.md
# Table-Driven Branching State Sequencer

This block is a state machine whose entire next-state and output behaviour lives in a writable dual-port memory. On every clock edge the memory is read at an address built from the current state code followed by a few branch bits. The word that comes back is captured in the synchronous read register. Its low field is the next state and its high field is the set of output bits, so that one register acts as both the state register and the output register. Each state therefore owns a block of 2**SEL_W consecutive words, one per branch value.

The external condition inputs outnumber the branch bits. They are registered first. A multiplexer steered by the low bits of the current state then picks one group of SEL_W registered inputs to drive the branch bits. Each state can look at a different small subset of a wider input set. A host write port rewrites any table word while the machine runs, which changes the sequence without rebuilding the design. When DUAL is set, the memory is split in two. The lower half runs machine A and the upper half runs an independent machine B, each with its own condition inputs.

Top module: `table_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, every active machine's state becomes 0, its condition register is cleared, and its outputs take the output field of that machine's base word (state 0, branch 0). The table contents are not changed by reset.
- R2: At each edge out of reset, a machine reads the word at address {half bit when DUAL, state, branch}. It then presents bits [STATE_W-1:0] of that word as state and bits [WORD_W-1:STATE_W] as outputs. STATE_W = ADDR_W - DUAL - SEL_W.
- R3: Condition inputs are captured in a register before use. A value present at edge k steers the transition made at edge k+1.
- R4: The group index g is the low GRP_W bits of the current state. The branch value is the registered condition bits [g*SEL_W +: SEL_W]. Inputs outside the selected group have no effect on that transition.
- R5: When wr_en is high at an edge, wr_data is stored at wr_addr. Every later read of that address returns it.
- R6: A read of the address being written at the same edge returns the old contents (read-first).
- R7: The initial image for physical address a, with s the state field and b the branch field of a, holds next state (s + STRIDE + b) mod 2**STATE_W and outputs equal to a. The default STRIDE is 1.
- R8: With DUAL = 1, machine A uses addresses with the top bit 0 and machine B uses addresses with the top bit 1. Each machine follows only its own condition inputs.
- R9: With DUAL = 0, state_b and out_b stay 0 and cond_b is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_a | input | SEL_W<<GRP_W | Condition inputs of machine A |
| cond_b | input | SEL_W<<GRP_W | Condition inputs of machine B (used when DUAL) |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | WORD_W | Host write word {outputs, next state} |
| state_a | output | ADDR_W-DUAL-SEL_W | Current state of machine A |
| out_a | output | WORD_W-STATE_W | Registered outputs of machine A |
| state_b | output | ADDR_W-DUAL-SEL_W | Current state of machine B |
| out_b | output | WORD_W-STATE_W | Registered outputs of machine B |

## Verification
The assertions check several properties on every cycle against a shadow copy of the table that follows host writes. Each state and output word must equal the word stored at the previous read address, with read-first collisions included. The branch bits must come from the right group of the previous cycle's condition inputs. Reset must land in state 0 with the base word's outputs. Only the bench's scenarios can show the following end to end: a specific branching path through the default image, a live rewrite that redirects the machine, a reset that picks up a rewritten base word, and the isolation of the two halves in dual mode.

// File: rtl/tseq_pkg.sv
// Shared helpers for the table-driven sequencer.
// Assumes word layout {outputs, next state} with next state in the low bits.
package tseq_pkg;

    // Default table image for a physical address: the next state steps by
    // stride plus branch value, and the outputs echo the physical address.
    function automatic logic [63:0] image_word(input int addr, input int state_w,
                                               input int sel_w, input int stride);
        int loc;
        int s;
        int b;
        int nxt;
        loc = addr & ((1 << (state_w + sel_w)) - 1);
        s   = loc >> sel_w;
        b   = loc & ((1 << sel_w) - 1);
        nxt = (s + stride + b) & ((1 << state_w) - 1);
        return (64'(addr) << state_w) | 64'(nxt);
    endfunction

endpackage

// File: rtl/tseq_cond_sel.sv
// Condition input register and state-steered group multiplexer.
// Assumes the condition inputs are arranged as 2**GRP_W groups of SEL_W bits.
module tseq_cond_sel #(
    parameter int SEL_W = 2,
    parameter int GRP_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [(SEL_W<<GRP_W)-1:0]   cond_in,
    input  logic [GRP_W-1:0]            grp,
    output logic [SEL_W-1:0]            branch
);
    localparam int NUM_COND = SEL_W << GRP_W;

    logic [NUM_COND-1:0] cond_q;

    // Capture condition inputs; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_in;
    end

    // Pick the group of branch bits that the current state looks at.
    always_comb begin
        branch = cond_q[grp*SEL_W +: SEL_W];
    end

endmodule

// File: rtl/tseq_ram.sv
// Table memory: read-only port A, port B with read plus host write.
// Both reads are synchronous and read-first. During reset, the read register
// keeps the output field of the addressed word and clears the state field.
// Assumes the caller forces the read address to the machine base in reset.
module tseq_ram #(
    parameter int ADDR_W  = 9,
    parameter int WORD_W  = 36,
    parameter int STATE_W = 7,
    parameter int SEL_W   = 2,
    parameter int STRIDE  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] q_a,
    output logic [WORD_W-1:0] q_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Load the parameterised start image.
    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = WORD_W'(tseq_pkg::image_word(i, STATE_W, SEL_W, STRIDE));
    end

    // Host write through port B.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Port A read register: doubles as state and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_a <= {mem[addr_a][WORD_W-1:STATE_W], {STATE_W{1'b0}}};
        else        q_a <= mem[addr_a];
    end

    // Port B read register: same behaviour for the second machine.
    always_ff @(posedge clk) begin
        if (!rst_n) q_b <= {mem[addr_b][WORD_W-1:STATE_W], {STATE_W{1'b0}}};
        else        q_b <= mem[addr_b];
    end

endmodule

// File: rtl/table_sequencer.sv
// Table-driven branching sequencer, top level.
// Next state and outputs come from a writable table addressed by
// {half, state, branch}. DUAL selects one machine or two independent halves.
// Assumes GRP_W <= state width and WORD_W > state width.
module table_sequencer #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36,
    parameter int SEL_W  = 2,
    parameter int GRP_W  = 2,
    parameter int DUAL   = 0,
    parameter int STRIDE = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [(SEL_W<<GRP_W)-1:0]             cond_a,
    input  logic [(SEL_W<<GRP_W)-1:0]             cond_b,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [WORD_W-1:0]                     wr_data,
    output logic [ADDR_W-DUAL-SEL_W-1:0]          state_a,
    output logic [WORD_W-(ADDR_W-DUAL-SEL_W)-1:0] out_a,
    output logic [ADDR_W-DUAL-SEL_W-1:0]          state_b,
    output logic [WORD_W-(ADDR_W-DUAL-SEL_W)-1:0] out_b
);
    localparam int MACH_AW = ADDR_W - DUAL;
    localparam int STATE_W = MACH_AW - SEL_W;

    logic [WORD_W-1:0]  q_a;
    logic [WORD_W-1:0]  q_b;
    logic [SEL_W-1:0]   br_a;
    logic [MACH_AW-1:0] loc_a;
    logic [ADDR_W-1:0]  rd_addr_a;
    logic [ADDR_W-1:0]  rd_addr_b;

    // Machine A: state and outputs straight from its read register.
    assign state_a = q_a[STATE_W-1:0];
    assign out_a   = q_a[WORD_W-1:STATE_W];

    tseq_cond_sel #(.SEL_W(SEL_W), .GRP_W(GRP_W)) u_sel_a (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_a),
        .grp(state_a[GRP_W-1:0]), .branch(br_a)
    );

    // Machine-local address of A; forced to the base entry during reset.
    assign loc_a = rst_n ? {state_a, br_a} : '0;

    generate
        if (DUAL != 0) begin : g_dual
            logic [SEL_W-1:0]   br_b;
            logic [MACH_AW-1:0] loc_b;

            tseq_cond_sel #(.SEL_W(SEL_W), .GRP_W(GRP_W)) u_sel_b (
                .clk(clk), .rst_n(rst_n), .cond_in(cond_b),
                .grp(state_b[GRP_W-1:0]), .branch(br_b)
            );

            // Machine B address in the upper half, A in the lower half.
            assign loc_b     = rst_n ? {state_b, br_b} : '0;
            assign rd_addr_a = {1'b0, loc_a};
            assign rd_addr_b = {1'b1, loc_b};
            assign state_b   = q_b[STATE_W-1:0];
            assign out_b     = q_b[WORD_W-1:STATE_W];
        end else begin : g_single
            // Single machine: port B idles at address 0, its outputs held low.
            assign rd_addr_a = loc_a;
            assign rd_addr_b = '0;
            assign state_b   = '0;
            assign out_b     = '0;
        end
    endgenerate

    tseq_ram #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .STATE_W(STATE_W),
        .SEL_W(SEL_W), .STRIDE(STRIDE)
    ) u_ram (
        .clk(clk), .rst_n(rst_n),
        .addr_a(rd_addr_a), .addr_b(rd_addr_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .q_a(q_a), .q_b(q_b)
    );

endmodule

// File: rtl/table_sequencer_chk.sv
// Assertion checker for table_sequencer, attached by bind.
// Keeps a shadow of the table that tracks host writes. It compares each
// registered word against the shadow word read on the previous edge.
module table_sequencer_chk #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36,
    parameter int SEL_W  = 2,
    parameter int GRP_W  = 2,
    parameter int DUAL   = 0,
    parameter int STRIDE = 1
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [(SEL_W<<GRP_W)-1:0]             cond_a,
    input logic [(SEL_W<<GRP_W)-1:0]             cond_b,
    input logic                                  wr_en,
    input logic [ADDR_W-1:0]                     wr_addr,
    input logic [WORD_W-1:0]                     wr_data,
    input logic [ADDR_W-1:0]                     rd_addr_a,
    input logic [ADDR_W-1:0]                     rd_addr_b,
    input logic [ADDR_W-DUAL-SEL_W-1:0]          state_a,
    input logic [WORD_W-(ADDR_W-DUAL-SEL_W)-1:0] out_a,
    input logic [ADDR_W-DUAL-SEL_W-1:0]          state_b,
    input logic [WORD_W-(ADDR_W-DUAL-SEL_W)-1:0] out_b
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int STATE_W  = ADDR_W - DUAL - SEL_W;
    localparam int NUM_COND = SEL_W << GRP_W;

    logic [WORD_W-1:0]   shadow [DEPTH];
    logic [WORD_W-1:0]   shadow_a;
    logic [WORD_W-1:0]   shadow_b;
    logic [WORD_W-1:0]   shadow_base_a;
    logic [NUM_COND-1:0] ca_d;
    logic [SEL_W-1:0]    exp_br_a;

    // Shadow table from the same start image.
    initial begin
        for (int i = 0; i < DEPTH; i++)
            shadow[i] = WORD_W'(tseq_pkg::image_word(i, STATE_W, SEL_W, STRIDE));
    end

    // Follow host writes into the shadow.
    always_ff @(posedge clk) begin
        if (wr_en) shadow[wr_addr] <= wr_data;
    end

    // Delayed copy of condition inputs for the branch check.
    always_ff @(posedge clk) begin
        ca_d <= cond_a;
    end

    assign shadow_a      = shadow[rd_addr_a];
    assign shadow_b      = shadow[rd_addr_b];
    assign shadow_base_a = shadow[0];
    assign exp_br_a      = ca_d[state_a[GRP_W-1:0]*SEL_W +: SEL_W];

    // R1: leaving reset lands in state 0 with the base word's outputs.
    a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_a == '0) && (out_a == $past(shadow_base_a[WORD_W-1:STATE_W])));

    // R2, R5, R6: word equals shadow contents read at the previous edge (read-first).
    a_r2_next_from_table: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({out_a, state_a} == $past(shadow_a)));

    // R3, R4: branch bits come from the state's group of last cycle's inputs.
    a_r4_branch_select: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_addr_a[SEL_W-1:0] == exp_br_a));

    generate
        if (DUAL != 0) begin : g_dual_chk
            // R8: machine B follows its own half of the table.
            a_r8_b_from_table: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ({out_b, state_b} == $past(shadow_b)));
            // R8: the two machines read opposite halves.
            a_r8_halves: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_addr_a[ADDR_W-1] && rd_addr_b[ADDR_W-1]);
        end else begin : g_single_chk
            // R9: idle machine outputs stay low whatever cond_b does.
            a_r9_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
                (state_b == '0) && (out_b == '0) && $stable(state_b));
        end
    endgenerate

endmodule

bind table_sequencer table_sequencer_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SEL_W(SEL_W),
    .GRP_W(GRP_W), .DUAL(DUAL), .STRIDE(STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cond_a(cond_a), .cond_b(cond_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .state_a(state_a), .out_a(out_a), .state_b(state_b), .out_b(out_b)
);

// File: tb/table_sequencer_test.sv
// Self-checking bench: one single-machine instance and one dual instance.
module table_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_d_n = 1'b0;
    logic [7:0]  cond_a = '0;
    logic [7:0]  cond_b = '0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic [6:0]  state_a, state_b;
    logic [28:0] out_a, out_b;

    logic [7:0]  cda = '0;
    logic [7:0]  cdb = '0;
    logic [5:0]  sda, sdb;
    logic [29:0] oda, odb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    table_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cond_a(cond_a), .cond_b(cond_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .state_a(state_a), .out_a(out_a), .state_b(state_b), .out_b(out_b)
    );

    table_sequencer #(.DUAL(1)) uut_dual (
        .clk(clk), .rst_n(rst_d_n), .cond_a(cda), .cond_b(cdb),
        .wr_en(1'b0), .wr_addr(9'd0), .wr_data(36'd0),
        .state_a(sda), .out_a(oda), .state_b(sdb), .out_b(odb)
    );

    // Compare one value; print a FAIL line on mismatch.
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle on the single instance, called at a falling edge.
    task automatic step(input logic [7:0] c, input logic we,
                        input logic [8:0] wa, input logic [35:0] wd);
        cond_a  = c;
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Stimulus and expected results: {cond, next state, outputs}.
    localparam logic [43:0] VEC [8] = '{
        {8'h0C, 7'd1,  29'd0},
        {8'h20, 7'd5,  29'd7},
        {8'hFF, 7'd6,  29'd20},
        {8'h02, 7'd10, 29'd27},
        {8'h80, 7'd11, 29'd40},
        {8'h01, 7'd14, 29'd46},
        {8'h40, 7'd15, 29'd56},
        {8'h00, 7'd17, 29'd61}
    };

    // Noise on the unused machine-B inputs of the single instance.
    always @(negedge clk) cond_b <= cond_b + 8'h35;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset, state 0 with the base word outputs (image gives 0).
        check("R1 reset state", 64'(state_a), 64'd0);
        check("R1 reset outputs", 64'(out_a), 64'd0);

        // R2 R3 R4 R7: walk the default image through a branching path.
        foreach (VEC[i]) begin
            step(VEC[i][43:36], 1'b0, '0, '0);
            check($sformatf("R3/R4 vec%0d state", i), 64'(state_a), 64'(VEC[i][35:29]));
            check($sformatf("R2/R7 vec%0d outputs", i), 64'(out_a), 64'(VEC[i][28:0]));
            check("R9 idle state_b", 64'(state_b), 64'd0);
            check("R9 idle out_b", 64'(out_b), 64'd0);
        end

        // R5: write word 72 while the machine reads 68.
        step(8'h00, 1'b1, 9'd72, {29'h0ABCDE, 7'd99});
        check("R5 pre-write step state", 64'(state_a), 64'd18);
        check("R5 pre-write step outputs", 64'(out_a), 64'd68);
        // R6: rewrite 72 while reading it; old (first write) contents return.
        step(8'h00, 1'b1, 9'd72, {29'h155555, 7'd5});
        check("R6 read-first state", 64'(state_a), 64'd99);
        check("R6 read-first outputs", 64'(out_a), 64'h0ABCDE);
        step(8'h00, 1'b0, '0, '0);
        check("R2 after jump state", 64'(state_a), 64'd100);
        check("R2 after jump outputs", 64'(out_a), 64'd396);

        // R1 R5: rewrite the base word, then reset picks up its outputs.
        step(8'h00, 1'b1, 9'd0, {29'h1F0F0F, 7'd42});
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state after rewrite", 64'(state_a), 64'd0);
        check("R1 reset outputs from base word", 64'(out_a), 64'h1F0F0F);
        step(8'h00, 1'b0, '0, '0);
        check("R5 new base next state", 64'(state_a), 64'd42);
        check("R5 new base outputs", 64'(out_a), 64'h1F0F0F);
        step(8'h00, 1'b0, '0, '0);
        check("R4 group 2 state", 64'(state_a), 64'd43);
        check("R4 group 2 outputs", 64'(out_a), 64'd168);

        // R8: dual-mode halves run independently.
        rst_d_n = 1'b1;
        check("R8 dual A reset state", 64'(sda), 64'd0);
        check("R8 dual B reset outputs", 64'(odb), 64'd256);
        cda = 8'h00; cdb = 8'h0C;
        @(posedge clk); @(negedge clk);
        check("R8 dual A step1 state", 64'(sda), 64'd1);
        check("R8 dual B step1 outputs", 64'(odb), 64'd256);
        cda = 8'h00; cdb = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R8 dual A step2 state", 64'(sda), 64'd2);
        check("R8 dual A step2 outputs", 64'(oda), 64'd4);
        check("R8 dual B step2 state", 64'(sdb), 64'd5);
        check("R8 dual B step2 outputs", 64'(odb), 64'd263);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule